// File: doc/BRIEF.md
# Two-Wire Potentiometer Command Decoder

This block is the slave side of the two-wire control port of a digitally controlled potentiometer. A fast system clock samples the serial clock and data lines through synchronisers. The block finds start and stop conditions and checks the slave address against a fixed type code and three strap pins. It then decodes one instruction byte and runs the short transaction that follows. Each byte it accepts is acknowledged by asserting an open-drain pull-down enable during the ninth clock. Register actions go to a register back end as one-cycle command pulses. Read data comes back from the back end and is shifted out MSB first.

The address byte is `0101` in bits 7:4, then strap bit A3 in bit 3, strap bit A2 in bit 2, a hard zero in bit 1 and strap bit A0 in bit 0. The instruction byte carries the opcode in bits 7:4, the register pointer in bits 3:2 and zeros in bits 1:0. Read and write data bytes are `00` followed by the six data bits. While the back end reports a nonvolatile write in progress, the address byte is not acknowledged, so the host can poll.

The controller states are:
- `S_IDLE`: no transaction.
- `S_ADDR`, `S_INSTR`, `S_WDATA`: receive a byte.
- `S_ADDR_ACK`, `S_INSTR_ACK`, `S_WDATA_ACK`: acknowledge a byte.
- `S_RDATA`: shift out read data.
- `S_RD_MACK`: the host's acknowledge slot after read data.
- `S_WAIT_STOP`: wait for a stop.
- `S_STEP`: increment/decrement mode.

The transitions are:
- A start from any state goes to `S_ADDR`.
- A stop from any state goes to `S_IDLE`.
- A receive state moves to its acknowledge state after eight bits if the byte is valid, or to `S_IDLE` if it is not.
- `S_INSTR_ACK` branches on the opcode to `S_WDATA`, `S_RDATA`, `S_STEP` or `S_WAIT_STOP`.
- `S_WDATA_ACK` and `S_RD_MACK` go to `S_WAIT_STOP`.

Top module: `pot_cmd_decoder`

## Requirements
- R1: After reset, `sda_pull` and `cmd_valid` are low.
- R2: An address byte equal to {0101, A3, A2, 0, A0} is acknowledged, where `strap[2]`=A3, `strap[1]`=A2 and `strap[0]`=A0. Any other byte is not acknowledged, and nothing more is acknowledged until the next start.
- R3: When `nv_busy` is high as the eighth address bit completes, the address is not acknowledged.
- R4: The valid opcodes are 1001 read wiper, 1010 write wiper, 1011 read data register, 1100 write data register, 1101 load wiper from data register, 1110 save wiper to data register, and 0010 step mode. A byte with any other opcode, or with bit 1 or bit 0 set, is not acknowledged and causes no command.
- R5: A write data byte with bits 7:6 equal to 00 is acknowledged. It produces one `cmd_valid` pulse with `cmd_kind` 1 (wiper) or 2 (data register), `cmd_ptr` set to the pointer and `cmd_data` set to bits 5:0. A data byte with either upper bit set is not acknowledged and causes no command.
- R6: A load instruction (kind 3) or a save instruction (kind 4) issues its command only on the stop that follows the instruction acknowledge. A repeated start in place of that stop issues nothing.
- R7: A read sends 00 followed by the six-bit value from `rd_data`, MSB first, then releases the line for the host's acknowledge. A read issues no command pulse.
- R8: In step mode, each SCL high pulse issues a step command at its falling edge: kind 5 when SDA was high at the rising edge, kind 6 when it was low. The final SCL high that carries the stop issues nothing.
- R9: A start or stop in the middle of a data byte aborts the transaction with no command.
- R10: A start in any state, including a repeated start, restarts address reception.
- R11: `sda_pull` is asserted only during an acknowledge slot of the slave, or while the slave sends a zero data bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| sda_pull | output | 1 | Open-drain enable; high pulls the data line low |
| strap | input | 3 | Address straps {A3, A2, A0} |
| nv_busy | input | 1 | Back end is busy with a nonvolatile write |
| rd_wiper | output | 1 | Read source select: 1 selects the wiper register, 0 selects a data register |
| rd_ptr | output | 2 | Data register pointer for reads |
| rd_data | input | 6 | Read value returned by the back end |
| cmd_valid | output | 1 | One-cycle command pulse |
| cmd_kind | output | 3 | Command kind, 1 to 6 as in R5, R6 and R8 |
| cmd_ptr | output | 2 | Register pointer of the command |
| cmd_data | output | 6 | Write data of the command |

## Verification
Directed transactions cover the following cases:
- each opcode, to tell the decode paths apart;
- addresses that differ from the accepted one in a single field (type code, strap bit, hard-zero bit), so that each part of the compare is tested on its own;
- instruction and data bytes that are otherwise legal but have a must-be-zero bit set;
- transfers ended by a stop and by a repeated start, which separate commit-on-stop from commit-on-byte;
- a mixed run of step pulses ending in a stop, which shows that the stop's own clock high is not counted.

A seeded random series of writes, reads and loads over random pointers and values then checks that read data round-trips through the back end model.

// File: rtl/pot_cmd_pkg.sv
package pot_cmd_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR,
        S_ADDR_ACK,
        S_INSTR,
        S_INSTR_ACK,
        S_WDATA,
        S_WDATA_ACK,
        S_RDATA,
        S_RD_MACK,
        S_WAIT_STOP,
        S_STEP
    } dec_state_t;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_RD_WIPER,
        OP_WR_WIPER,
        OP_RD_DATA,
        OP_WR_DATA,
        OP_LOAD,
        OP_SAVE,
        OP_STEP
    } op_t;

    localparam logic [2:0] KIND_WR_WIPER = 3'd1;
    localparam logic [2:0] KIND_WR_DATA  = 3'd2;
    localparam logic [2:0] KIND_LOAD     = 3'd3;
    localparam logic [2:0] KIND_SAVE     = 3'd4;
    localparam logic [2:0] KIND_STEP_UP  = 3'd5;
    localparam logic [2:0] KIND_STEP_DN  = 3'd6;

    function automatic op_t opcode_to_op(input logic [3:0] code);
        op_t r;
        case (code)
            4'b1001: r = OP_RD_WIPER;
            4'b1010: r = OP_WR_WIPER;
            4'b1011: r = OP_RD_DATA;
            4'b1100: r = OP_WR_DATA;
            4'b1101: r = OP_LOAD;
            4'b1110: r = OP_SAVE;
            4'b0010: r = OP_STEP;
            default: r = OP_NONE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pot_line_sync.sv
module pot_line_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '1;
        end else begin
            chain[0] <= din;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/pot_bus_events.sv
module pot_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise = scl_s & ~scl_q;
    assign scl_fall = ~scl_s & scl_q;
    assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/pot_byte_check.sv
module pot_byte_check
    import pot_cmd_pkg::*;
#(
    parameter logic [3:0] DEV_TYPE = 4'b0101,
    parameter int         DATA_W   = 6
) (
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [2:0]        strap,
    output logic              addr_ok,
    output logic              instr_ok,
    output logic              data_ok,
    output op_t               op
);
    localparam int PAD_W = BYTE_W - DATA_W;

    always_comb begin
        addr_ok = (rx_byte[7:4] == DEV_TYPE) && (rx_byte[3] == strap[2]) &&
                  (rx_byte[2] == strap[1]) && !rx_byte[1] &&
                  (rx_byte[0] == strap[0]);
        op       = opcode_to_op(rx_byte[7:4]);
        instr_ok = (op != OP_NONE) && (rx_byte[1:0] == 2'b00);
        data_ok  = (rx_byte[BYTE_W-1 -: PAD_W] == '0);
    end
endmodule

// File: rtl/pot_cmd_decoder.sv
module pot_cmd_decoder
    import pot_cmd_pkg::*;
#(
    parameter logic [3:0] DEV_TYPE    = 4'b0101,
    parameter int         DATA_W      = 6,
    parameter int         PTR_W       = 2,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_pull,
    input  logic [2:0]        strap,
    input  logic              nv_busy,
    output logic              rd_wiper,
    output logic [PTR_W-1:0]  rd_ptr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              cmd_valid,
    output logic [2:0]        cmd_kind,
    output logic [PTR_W-1:0]  cmd_ptr,
    output logic [DATA_W-1:0] cmd_data
);
    localparam int CNT_W   = $clog2(BYTE_W + 1);
    localparam int PAD_W   = BYTE_W - DATA_W;
    localparam int PTR_LSB = 2;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_TX  = CNT_W'(BYTE_W - 1);

    // line synchronisation and bus conditions
    logic [1:0] lines_s;
    logic       scl_s, sda_s;
    logic       scl_rise, scl_fall, start_ev, stop_ev;

    pot_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({scl_in, sda_in}),
        .dout (lines_s)
    );
    assign scl_s = lines_s[1];
    assign sda_s = lines_s[0];

    pot_bus_events u_events (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_s   (scl_s),
        .sda_s   (sda_s),
        .scl_rise(scl_rise),
        .scl_fall(scl_fall),
        .start_ev(start_ev),
        .stop_ev (stop_ev)
    );

    // state and datapath registers
    dec_state_t          state, nxt;
    logic [BYTE_W-1:0]   rx_byte;
    logic [BYTE_W-1:0]   tx_byte, tx_nxt;
    logic [CNT_W-1:0]    bit_cnt;
    op_t                 op_q;
    logic [PTR_W-1:0]    ptr_q;
    logic                step_dir, step_armed;

    logic addr_ok, instr_ok, data_ok;
    op_t  dec_op;

    pot_byte_check #(.DEV_TYPE(DEV_TYPE), .DATA_W(DATA_W)) u_check (
        .rx_byte (rx_byte),
        .strap   (strap),
        .addr_ok (addr_ok),
        .instr_ok(instr_ok),
        .data_ok (data_ok),
        .op      (dec_op)
    );

    logic byte_done;
    assign byte_done = scl_fall && (bit_cnt == FULL_CNT);

    // next-state logic
    always_comb begin
        nxt = state;
        if (start_ev) begin
            nxt = S_ADDR;
        end else if (stop_ev) begin
            nxt = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE:      nxt = S_IDLE;
                S_ADDR:      if (byte_done) nxt = (addr_ok && !nv_busy) ? S_ADDR_ACK : S_IDLE;
                S_ADDR_ACK:  if (scl_fall) nxt = S_INSTR;
                S_INSTR:     if (byte_done) nxt = instr_ok ? S_INSTR_ACK : S_IDLE;
                S_INSTR_ACK: if (scl_fall) begin
                    case (op_q)
                        OP_WR_WIPER, OP_WR_DATA: nxt = S_WDATA;
                        OP_RD_WIPER, OP_RD_DATA: nxt = S_RDATA;
                        OP_STEP:                 nxt = S_STEP;
                        default:                 nxt = S_WAIT_STOP;
                    endcase
                end
                S_WDATA:     if (byte_done) nxt = data_ok ? S_WDATA_ACK : S_IDLE;
                S_WDATA_ACK: if (scl_fall) nxt = S_WAIT_STOP;
                S_RDATA:     if (scl_fall && bit_cnt == LAST_TX) nxt = S_RD_MACK;
                S_RD_MACK:   if (scl_fall) nxt = S_WAIT_STOP;
                S_WAIT_STOP: nxt = S_WAIT_STOP;
                S_STEP:      nxt = S_STEP;
                default:     nxt = S_IDLE;
            endcase
        end
    end

    // transmit shifter next value
    always_comb begin
        tx_nxt = tx_byte;
        if (!start_ev && !stop_ev) begin
            if (state == S_INSTR_ACK && nxt == S_RDATA) begin
                tx_nxt = {{PAD_W{1'b0}}, rd_data};
            end else if (state == S_RDATA && scl_fall) begin
                tx_nxt = {tx_byte[BYTE_W-2:0], 1'b0};
            end
        end
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            rx_byte    <= '0;
            tx_byte    <= '0;
            bit_cnt    <= '0;
            op_q       <= OP_NONE;
            ptr_q      <= '0;
            step_dir   <= 1'b0;
            step_armed <= 1'b0;
        end else begin
            state   <= nxt;
            tx_byte <= tx_nxt;
            if (start_ev || stop_ev) begin
                bit_cnt    <= '0;
                step_armed <= 1'b0;
                if (start_ev) op_q <= OP_NONE;
            end else begin
                case (state)
                    S_ADDR, S_INSTR, S_WDATA: begin
                        if (scl_rise && bit_cnt != FULL_CNT) begin
                            rx_byte <= {rx_byte[BYTE_W-2:0], sda_s};
                            bit_cnt <= bit_cnt + CNT_W'(1);
                        end
                        if (state == S_INSTR && nxt == S_INSTR_ACK) begin
                            op_q  <= dec_op;
                            ptr_q <= rx_byte[PTR_LSB +: PTR_W];
                        end
                    end
                    S_ADDR_ACK, S_INSTR_ACK, S_WDATA_ACK, S_RD_MACK: begin
                        if (scl_fall) bit_cnt <= '0;
                    end
                    S_RDATA: begin
                        if (scl_fall) bit_cnt <= bit_cnt + CNT_W'(1);
                    end
                    S_STEP: begin
                        if (scl_rise) begin
                            step_dir   <= sda_s;
                            step_armed <= 1'b1;
                        end else if (scl_fall) begin
                            step_armed <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // command and pull-down decisions
    logic       fire;
    logic [2:0] fire_kind;
    logic       pull_nxt;

    always_comb begin
        fire      = 1'b0;
        fire_kind = '0;
        if (stop_ev && state == S_WAIT_STOP && (op_q == OP_LOAD || op_q == OP_SAVE)) begin
            fire      = 1'b1;
            fire_kind = (op_q == OP_LOAD) ? KIND_LOAD : KIND_SAVE;
        end else if (!start_ev && !stop_ev && state == S_WDATA && nxt == S_WDATA_ACK) begin
            fire      = 1'b1;
            fire_kind = (op_q == OP_WR_WIPER) ? KIND_WR_WIPER : KIND_WR_DATA;
        end else if (!start_ev && !stop_ev && state == S_STEP && scl_fall && step_armed) begin
            fire      = 1'b1;
            fire_kind = step_dir ? KIND_STEP_UP : KIND_STEP_DN;
        end
        pull_nxt = (nxt == S_ADDR_ACK) || (nxt == S_INSTR_ACK) || (nxt == S_WDATA_ACK) ||
                   ((nxt == S_RDATA) && !tx_nxt[BYTE_W-1]);
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_pull  <= 1'b0;
            cmd_valid <= 1'b0;
            cmd_kind  <= '0;
            cmd_ptr   <= '0;
            cmd_data  <= '0;
        end else begin
            sda_pull  <= pull_nxt;
            cmd_valid <= fire;
            if (fire) begin
                cmd_kind <= fire_kind;
                cmd_ptr  <= ptr_q;
                cmd_data <= (state == S_WDATA) ? rx_byte[DATA_W-1:0] : '0;
            end
        end
    end

    assign rd_wiper = (op_q == OP_RD_WIPER);
    assign rd_ptr   = ptr_q;

    // assertions
    assert_pull_owner_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sda_pull |-> (state inside {S_ADDR_ACK, S_INSTR_ACK, S_WDATA_ACK, S_RDATA}));

    assert_busy_nack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ADDR && byte_done && nv_busy) |=> (state != S_ADDR_ACK));

    assert_bad_instr_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_INSTR && byte_done && !instr_ok) |=> (state == S_IDLE && !sda_pull));

    assert_cmd_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    assert_read_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state inside {S_RDATA, S_RD_MACK}) |-> !cmd_valid);

    assert_step_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_kind == KIND_STEP_UP || cmd_kind == KIND_STEP_DN)) |-> $past(scl_fall));

    assert_start_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (state == S_ADDR && bit_cnt == '0));
endmodule

// File: tb/pot_cmd_decoder_bench.sv
module pot_cmd_decoder_bench;
    import pot_cmd_pkg::*;

    localparam int         HALF  = 6;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [7:0] ADDR_OK = {4'b0101, STRAP[2], STRAP[1], 1'b0, STRAP[0]};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic nv_busy = 1'b0;
    logic sda_pull;
    logic sda_line;
    assign sda_line = m_sda & ~sda_pull;

    logic       rd_wiper;
    logic [1:0] rd_ptr;
    logic [5:0] rd_data;
    logic       cmd_valid;
    logic [2:0] cmd_kind;
    logic [1:0] cmd_ptr;
    logic [5:0] cmd_data;

    pot_cmd_decoder u_pot_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
        .sda_pull(sda_pull), .strap(STRAP), .nv_busy(nv_busy),
        .rd_wiper(rd_wiper), .rd_ptr(rd_ptr), .rd_data(rd_data),
        .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_ptr(cmd_ptr), .cmd_data(cmd_data)
    );

    // register back end model and command log
    logic [5:0] be_wiper;
    logic [5:0] be_dr [4];
    int         cmd_count;
    logic [2:0] log_kind [256];
    logic [1:0] log_ptr  [256];
    logic [5:0] log_data [256];

    assign rd_data = rd_wiper ? be_wiper : be_dr[rd_ptr];

    always @(posedge clk) begin
        if (!rst_n) begin
            be_wiper  <= '0;
            for (int i = 0; i < 4; i++) be_dr[i] <= '0;
            cmd_count <= 0;
        end else if (cmd_valid) begin
            log_kind[cmd_count[7:0]] <= cmd_kind;
            log_ptr[cmd_count[7:0]]  <= cmd_ptr;
            log_data[cmd_count[7:0]] <= cmd_data;
            cmd_count <= cmd_count + 1;
            case (cmd_kind)
                KIND_WR_WIPER: be_wiper <= cmd_data;
                KIND_WR_DATA:  be_dr[cmd_ptr] <= cmd_data;
                KIND_LOAD:     be_wiper <= be_dr[cmd_ptr];
                KIND_SAVE:     be_dr[cmd_ptr] <= be_wiper;
                KIND_STEP_UP:  if (be_wiper != 6'd63) be_wiper <= be_wiper + 6'd1;
                KIND_STEP_DN:  if (be_wiper != 6'd0) be_wiper <= be_wiper - 6'd1;
                default: ;
            endcase
        end
    end

    // reference state
    int ref_wiper;
    int ref_dr [4];
    int n_checks = 0;
    int n_errors = 0;

    task automatic check_eq(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] mk_instr(input logic [3:0] opc, input int p);
        return {opc, p[1:0], 2'b00};
    endfunction

    task automatic ws(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; ws(HALF);
        m_scl = 1'b1; ws(HALF);
        m_sda = 1'b0; ws(HALF);
        m_scl = 1'b0; ws(HALF);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; ws(HALF);
        m_scl = 1'b1; ws(HALF);
        m_sda = 1'b1; ws(HALF);
    endtask

    task automatic clock_bit(input logic b, output logic s);
        m_sda = b; ws(HALF);
        m_scl = 1'b1; ws(HALF);
        s = sda_line;
        m_scl = 1'b0; ws(2);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clock_bit(v[i], s);
        clock_bit(1'b1, s);
        ack = !s;
    endtask

    task automatic recv_byte(input logic m_ack, output logic [7:0] v);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, s);
            v[i] = s;
        end
        clock_bit(!m_ack, s);
    endtask

    task automatic do_write(input logic to_wiper, input int p, input int d, input string tag);
        logic a;
        int base;
        base = cmd_count;
        bus_start();
        send_byte(ADDR_OK, a);
        send_byte(mk_instr(to_wiper ? 4'b1010 : 4'b1100, p), a);
        check_eq({tag, " instr ack R4"}, int'(a), 1);
        send_byte({2'b00, d[5:0]}, a);
        check_eq({tag, " data ack R5"}, int'(a), 1);
        bus_stop();
        ws(4);
        check_eq({tag, " cmd count R5"}, cmd_count - base, 1);
        check_eq({tag, " cmd kind R5"}, int'(log_kind[base[7:0]]), to_wiper ? 1 : 2);
        check_eq({tag, " cmd data R5"}, int'(log_data[base[7:0]]), d);
        if (!to_wiper) check_eq({tag, " cmd ptr R5"}, int'(log_ptr[base[7:0]]), p);
        if (to_wiper) ref_wiper = d; else ref_dr[p] = d;
    endtask

    task automatic do_read(input logic from_wiper, input int p, input int exp, input string tag);
        logic a;
        logic [7:0] v;
        int base;
        base = cmd_count;
        bus_start();
        send_byte(ADDR_OK, a);
        send_byte(mk_instr(from_wiper ? 4'b1001 : 4'b1011, p), a);
        recv_byte(1'b0, v);
        bus_stop();
        ws(4);
        check_eq({tag, " read value R7"}, int'(v), exp);
        check_eq({tag, " read no cmd R7"}, cmd_count - base, 0);
    endtask

    task automatic do_load(input int p, input string tag);
        logic a;
        int base;
        base = cmd_count;
        bus_start();
        send_byte(ADDR_OK, a);
        send_byte(mk_instr(4'b1101, p), a);
        ws(4);
        check_eq({tag, " no cmd before stop R6"}, cmd_count - base, 0);
        bus_stop();
        ws(4);
        check_eq({tag, " load on stop R6"}, cmd_count - base, 1);
        check_eq({tag, " load kind R6"}, int'(log_kind[base[7:0]]), 3);
        check_eq({tag, " load ptr R6"}, int'(log_ptr[base[7:0]]), p);
        ref_wiper = ref_dr[p];
    endtask

    logic       a;
    logic [7:0] rv;
    int         base;

    initial begin
        void'($urandom(32'd2024));
        ref_wiper = 0;
        for (int i = 0; i < 4; i++) ref_dr[i] = 0;
        ws(5);
        check_eq("reset pull R1", int'(sda_pull), 0);
        check_eq("reset cmd R1", int'(cmd_valid), 0);
        rst_n = 1'b1;
        ws(5);

        // basic write and read-back paths
        do_write(1'b1, 0, 42, "wr wiper");
        do_read(1'b1, 0, 42, "rd wiper");
        do_write(1'b0, 2, 21, "wr dr2");
        do_read(1'b0, 2, 21, "rd dr2");
        do_load(2, "load dr2");
        do_read(1'b1, 0, 21, "rd wiper after load");

        // save ended by repeated start: nothing issued, new address accepted
        base = cmd_count;
        bus_start();
        send_byte(ADDR_OK, a);
        send_byte(mk_instr(4'b1110, 1), a);
        check_eq("save instr ack R4", int'(a), 1);
        bus_start();
        send_byte(ADDR_OK, a);
        check_eq("repeated start address ack R10", int'(a), 1);
        bus_stop();
        ws(4);
        check_eq("save cancelled by restart R6", cmd_count - base, 0);

        // address mismatches
        bus_start(); send_byte(8'h51, a); check_eq("A3 mismatch nack R2", int'(a), 0);
        send_byte(mk_instr(4'b1010, 0), a); check_eq("no ack after bad addr R2", int'(a), 0);
        bus_stop();
        bus_start(); send_byte(8'h5B, a); check_eq("zero bit set nack R2", int'(a), 0); bus_stop();
        bus_start(); send_byte(8'h49, a); check_eq("type code nack R2", int'(a), 0); bus_stop();
        bus_start(); send_byte(ADDR_OK ^ 8'h01, a); check_eq("A0 mismatch nack R2", int'(a), 0); bus_stop();

        // busy polling
        nv_busy = 1'b1;
        bus_start(); send_byte(ADDR_OK, a); check_eq("busy nack R3", int'(a), 0); bus_stop();
        nv_busy = 1'b0;
        bus_start(); send_byte(ADDR_OK, a); check_eq("idle ack R2", int'(a), 1); bus_stop();

        // bad instructions and bad data
        base = cmd_count;
        bus_start(); send_byte(ADDR_OK, a); send_byte(8'h30, a);
        check_eq("unknown opcode nack R4", int'(a), 0); bus_stop();
        bus_start(); send_byte(ADDR_OK, a); send_byte(8'hA1, a);
        check_eq("low bit set nack R4", int'(a), 0);
        send_byte(8'h05, a); check_eq("no data ack after bad instr R4", int'(a), 0); bus_stop();
        bus_start(); send_byte(ADDR_OK, a); send_byte(mk_instr(4'b1010, 0), a);
        send_byte(8'h40, a); check_eq("data upper bit nack R5", int'(a), 0); bus_stop();
        ws(4);
        check_eq("no cmd from bad bytes R4", cmd_count - base, 0);
        do_read(1'b1, 0, ref_wiper, "wiper kept after bad data R5");

        // mid-byte abort by start, then by stop
        base = cmd_count;
        bus_start(); send_byte(ADDR_OK, a); send_byte(mk_instr(4'b1010, 0), a);
        for (int i = 0; i < 4; i++) clock_bit(1'b1, a);
        bus_start(); send_byte(ADDR_OK, a); send_byte(mk_instr(4'b1100, 3), a);
        for (int i = 0; i < 5; i++) clock_bit(1'b0, a);
        bus_stop();
        ws(4);
        check_eq("abort no cmd R9", cmd_count - base, 0);
        do_read(1'b0, 3, ref_dr[3], "dr3 kept after abort R9");

        // step mode
        do_write(1'b1, 0, 10, "wr wiper before step");
        base = cmd_count;
        bus_start(); send_byte(ADDR_OK, a); send_byte(mk_instr(4'b0010, 0), a);
        check_eq("step instr ack R4", int'(a), 1);
        clock_bit(1'b1, a); clock_bit(1'b1, a); clock_bit(1'b0, a);
        bus_stop();
        ws(4);
        check_eq("step count R8", cmd_count - base, 3);
        check_eq("step 1 up R8", int'(log_kind[base[7:0]]), 5);
        check_eq("step 2 up R8", int'(log_kind[8'(base + 1)]), 5);
        check_eq("step 3 down R8", int'(log_kind[8'(base + 2)]), 6);
        ref_wiper = 11;
        do_read(1'b1, 0, 11, "wiper after steps R8");

        // seeded random series
        for (int it = 0; it < 30; it++) begin
            int k, p, d;
            k = int'($urandom_range(0, 4));
            p = int'($urandom_range(0, 3));
            d = int'($urandom_range(0, 63));
            case (k)
                0: do_write(1'b1, 0, d, "rand wr wiper");
                1: do_write(1'b0, p, d, "rand wr dr");
                2: do_read(1'b1, 0, ref_wiper, "rand rd wiper");
                3: do_read(1'b0, p, ref_dr[p], "rand rd dr");
                default: do_load(p, "rand load");
            endcase
        end

        check_eq("idle pull at end R11", int'(sda_pull), 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule